// File: doc/BRIEF.md
# RV32I Control-Transfer Next-PC Unit

This block holds the program counter of a 32-bit integer core and resolves every control-transfer instruction. On each enabled clock edge it decodes the instruction word presented to it and loads the PC with one of three values: the sequential address, a PC-relative target, or a register-relative target. The inputs are the instruction word and the two source operand values read from the register file.

For the two jump instructions it presents a link value and a write enable for the destination register. For every jump and every taken branch it raises a taken flag, which a pipeline can use to flush. Reserved control-transfer encodings raise an illegal flag and are otherwise treated as plain instructions. Any instruction that does not transfer control advances the PC by 4.

Top module: `ctl_next_pc`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with the parameter `RESET_VEC`. Reset is synchronous and takes priority over `en`.
- R2: Opcode 1101111 (jump-and-link) loads the PC with PC + sext({inst[31], inst[19:12], inst[20], inst[30:21], 0}).
  - It raises `taken`.
  - It raises `link_we` when rd (inst[11:7]) is non-zero.
- R3: Opcode 1100111 with funct3 (inst[14:12]) = 000 (register jump) loads the PC with (rs1_val + sext(inst[31:20])) with bit 0 cleared.
  - The target uses the rs1 operand as presented.
  - It raises `taken`, and raises `link_we` when rd is non-zero.
- R4: Opcode 1100011 is a conditional branch, and funct3 selects the test:
  - 000 equal, 001 not equal;
  - 100 signed less-than, 101 signed greater-or-equal;
  - 110 unsigned less-than, 111 unsigned greater-or-equal.
  - When the test holds, the PC becomes PC + sext({inst[31], inst[7], inst[30:25], inst[11:8], 0}) and `taken` is raised.
- R5: A branch whose test fails advances the PC by 4 with `taken` low. A branch never raises `link_we`.
- R6: A jump with rd = x0 still updates the PC and raises `taken`, but `link_we` stays low.
- R7: A branch with funct3 010 or 011, and a register jump with non-zero funct3, raise `illegal`. They advance the PC by 4, with `taken` and `link_we` low.
- R8: While `en` is low the PC holds its value, and `taken`, `link_we` and `illegal` are low.
- R9: Any other opcode advances the PC by 4, with `taken`, `link_we` and `illegal` low.
- R10: `link_val` equals the current PC + 4, and `link_rd` equals inst[11:7]. Both are computed from the PC before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Instruction valid; the PC updates only when high |
| instr | input | 32 | Instruction word at the current PC |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| pc_q | output | 32 | Current program counter |
| link_val | output | 32 | Return address (PC + 4) |
| link_rd | output | 5 | Destination register index for the link |
| link_we | output | 1 | Link write enable |
| taken | output | 1 | Jump or taken branch this cycle |
| illegal | output | 1 | Reserved control-transfer encoding |

## Verification
The only internal state is the PC. A wrong PC shows on `pc_q` one cycle after the faulty update, and it also shows at once in `link_val`. A wrong decode or a wrong comparison shows on `taken`, `link_we` and `illegal` combinationally, in the same cycle as the instruction. Its effect on the PC then shows at the next edge. The bench keeps its own running PC model, so one bad update moves every later expected target and is reported on every following check.

// File: rtl/ctl_next_pc.sv
module ctl_next_pc #(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] instr,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic [31:0] pc_q,
  output logic [31:0] link_val,
  output logic [4:0]  link_rd,
  output logic        link_we,
  output logic        taken,
  output logic        illegal
);

  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam logic [6:0] OP_BR   = 7'b1100011;

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic        is_jal, is_jalr, is_br, jalr_ok, br_ok;
  logic        cond, jump, br_take;
  logic [31:0] imm_j, imm_b, imm_i;
  logic [31:0] seq_pc, rel_tgt, jalr_sum, jalr_tgt, next_pc;

  assign opc     = instr[6:0];
  assign f3      = instr[14:12];
  assign is_jal  = opc == OP_JAL;
  assign is_jalr = opc == OP_JALR;
  assign is_br   = opc == OP_BR;
  assign jalr_ok = is_jalr && (f3 == 3'b000);
  assign br_ok   = is_br && (f3[2:1] != 2'b01);

  assign imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm_i = {{20{instr[31]}}, instr[31:20]};

  always_comb begin
    case (f3)
      3'b000:  cond = rs1_val == rs2_val;
      3'b001:  cond = rs1_val != rs2_val;
      3'b100:  cond = $signed(rs1_val) <  $signed(rs2_val);
      3'b101:  cond = $signed(rs1_val) >= $signed(rs2_val);
      3'b110:  cond = rs1_val <  rs2_val;
      3'b111:  cond = rs1_val >= rs2_val;
      default: cond = 1'b0;
    endcase
  end

  assign jump     = is_jal || jalr_ok;
  assign br_take  = br_ok && cond;
  assign seq_pc   = pc_q + 32'd4;
  assign rel_tgt  = pc_q + (is_jal ? imm_j : imm_b);
  assign jalr_sum = rs1_val + imm_i;
  assign jalr_tgt = {jalr_sum[31:1], 1'b0};

  always_comb begin
    if (is_jal || br_take) next_pc = rel_tgt;
    else if (jalr_ok)      next_pc = jalr_tgt;
    else                   next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= RESET_VEC;
    else if (en) pc_q <= next_pc;
  end

  assign link_val = seq_pc;
  assign link_rd  = instr[11:7];
  assign link_we  = en && jump && (link_rd != 5'd0);
  assign taken    = en && (jump || br_take);
  assign illegal  = en && ((is_jalr && !jalr_ok) || (is_br && !br_ok));

  a_r1_reset_vec: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_q));

  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> !taken && !link_we && !illegal);

  a_r6_x0_no_link: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_rd != 5'd0);

  a_r5_branch_no_link: assert property (@(posedge clk) disable iff (rst)
    is_br |-> !link_we);

  a_r7_illegal_seq: assert property (@(posedge clk) disable iff (rst)
    illegal |=> pc_q == $past(pc_q) + 32'd4);

  a_r7_illegal_not_taken: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !taken && !link_we);

  a_r3_jalr_even: assert property (@(posedge clk) disable iff (rst)
    (en && jalr_ok) |=> !pc_q[0]);

  a_r9_plain_seq: assert property (@(posedge clk) disable iff (rst)
    (en && !taken) |=> pc_q == $past(pc_q) + 32'd4);

endmodule

// File: tb/sim_ctl_next_pc.sv
module sim_ctl_next_pc;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [31:0] instr = 32'h0000_0013, rs1_val = '0, rs2_val = '0;
  logic [31:0] pc_q, link_val;
  logic [4:0]  link_rd;
  logic link_we, taken, illegal;
  int n_chk = 0, n_fail = 0;
  logic [31:0] pc_m;

  always #10 clk = ~clk;

  ctl_next_pc #(.RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .pc_q(pc_q), .link_val(link_val), .link_rd(link_rd), .link_we(link_we),
    .taken(taken), .illegal(illegal));

  // op: 0 jal, 1 jalr, 2 branch, 3 plain
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  f3;
    logic [4:0]  rd;
    logic [31:0] off;
    logic [31:0] a;
    logic [31:0] b;
    logic        tk;
    logic        we;
    logic        ill;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd3, 3'd0, 5'd1, 32'h0,         32'h0,         32'h0,         1'b0, 1'b0, 1'b0}, // R9
    '{2'd0, 3'd0, 5'd1, 32'h0000_0800, 32'h0,         32'h0,         1'b1, 1'b1, 1'b0}, // R2
    '{2'd0, 3'd0, 5'd0, 32'hFFFF_FFF0, 32'h0,         32'h0,         1'b1, 1'b0, 1'b0}, // R6
    '{2'd0, 3'd0, 5'd5, 32'h000F_FFFE, 32'h0,         32'h0,         1'b1, 1'b1, 1'b0}, // R2 max
    '{2'd0, 3'd0, 5'd1, 32'hFFF0_0000, 32'h0,         32'h0,         1'b1, 1'b1, 1'b0}, // R2 min
    '{2'd1, 3'd0, 5'd1, 32'h0000_07FF, 32'h0000_2001, 32'h0,         1'b1, 1'b1, 1'b0}, // R3
    '{2'd1, 3'd0, 5'd0, 32'hFFFF_F800, 32'h0000_3000, 32'h0,         1'b1, 1'b0, 1'b0}, // R3 R6
    '{2'd1, 3'd1, 5'd1, 32'h0000_0010, 32'h0000_4000, 32'h0,         1'b0, 1'b0, 1'b1}, // R7
    '{2'd2, 3'd0, 5'd0, 32'h0000_0008, 32'd5,         32'd5,         1'b1, 1'b0, 1'b0}, // R4 beq
    '{2'd2, 3'd0, 5'd0, 32'h0000_0008, 32'd5,         32'd6,         1'b0, 1'b0, 1'b0}, // R5
    '{2'd2, 3'd1, 5'd0, 32'hFFFF_FFFC, 32'd5,         32'd6,         1'b1, 1'b0, 1'b0}, // R4 bne
    '{2'd2, 3'd4, 5'd0, 32'h0000_0FFE, 32'hFFFF_FFFF, 32'd1,         1'b1, 1'b0, 1'b0}, // R4 blt
    '{2'd2, 3'd6, 5'd0, 32'h0000_0010, 32'hFFFF_FFFF, 32'd1,         1'b0, 1'b0, 1'b0}, // R4 bltu
    '{2'd2, 3'd5, 5'd0, 32'hFFFF_F000, 32'd1,         32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0}, // R4 bge
    '{2'd2, 3'd7, 5'd0, 32'h0000_0010, 32'd1,         32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0}, // R4 bgeu
    '{2'd2, 3'd5, 5'd0, 32'h0000_0020, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0}, // R4 bge eq
    '{2'd2, 3'd7, 5'd0, 32'h0000_0040, 32'd9,         32'd9,         1'b1, 1'b0, 1'b0}, // R4 bgeu eq
    '{2'd2, 3'd4, 5'd0, 32'h0000_0040, 32'd9,         32'd9,         1'b0, 1'b0, 1'b0}, // R5 blt eq
    '{2'd2, 3'd2, 5'd0, 32'h0000_0040, 32'd1,         32'd1,         1'b0, 1'b0, 1'b1}, // R7
    '{2'd2, 3'd3, 5'd0, 32'h0000_0040, 32'd1,         32'd2,         1'b0, 1'b0, 1'b1}, // R7
    '{2'd2, 3'd6, 5'd0, 32'h0000_0100, 32'd1,         32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0}  // R4 bltu
  };

  function automatic logic [31:0] enc(vec_t v);
    case (v.op)
      2'd0: enc = {v.off[20], v.off[10:1], v.off[11], v.off[19:12], v.rd, 7'b1101111};
      2'd1: enc = {v.off[11:0], 5'd2, v.f3, v.rd, 7'b1100111};
      2'd2: enc = {v.off[12], v.off[10:5], 5'd3, 5'd2, v.f3, v.off[4:1], v.off[11], 7'b1100011};
      default: enc = {12'd10, 5'd0, 3'd0, v.rd, 7'b0010011};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset pc", pc_q, RV);
    check("R8 idle flags", {29'd0, taken, link_we, illegal}, 32'd0);
    pc_m = RV;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] exp_pc;
      v = TBL[i];
      instr = enc(v); rs1_val = v.a; rs2_val = v.b; en = 1'b1;
      #2;
      check("R2 R3 R4 taken", {31'd0, taken}, {31'd0, v.tk});
      check("R5 R6 link_we", {31'd0, link_we}, {31'd0, v.we});
      check("R7 illegal", {31'd0, illegal}, {31'd0, v.ill});
      check("R10 link_val", link_val, pc_m + 32'd4);
      if (!v.tk)           exp_pc = pc_m + 32'd4;
      else if (v.op == 2'd1) exp_pc = (v.a + v.off) & 32'hFFFF_FFFE;
      else                 exp_pc = pc_m + v.off;
      @(posedge clk); #2;
      check("R2 R3 R4 R5 next pc", pc_q, exp_pc);
      pc_m = exp_pc;
      @(negedge clk);
    end

    // R10 link_rd and R8 hold with a jump presented while disabled
    en = 1'b0;
    instr = {1'b0, 10'd8, 1'b0, 8'd0, 5'd7, 7'b1101111};
    #2;
    check("R10 link_rd", {27'd0, link_rd}, 32'd7);
    check("R8 no taken while idle", {30'd0, taken, link_we}, 32'd0);
    @(posedge clk); #2;
    check("R8 pc held", pc_q, pc_m);
    @(negedge clk);

    // R3 rd equals rs1: target from presented operand
    en = 1'b1; rs1_val = 32'h0000_5003;
    instr = {12'h004, 5'd1, 3'd0, 5'd1, 7'b1100111};
    #2;
    check("R10 link before update", link_val, pc_m + 32'd4);
    @(posedge clk); #2;
    check("R3 odd sum cleared", pc_q, 32'h0000_5006);
    @(negedge clk);

    // R1 reset overrides enable
    rst = 1'b1;
    @(posedge clk); #2;
    check("R1 reset over en", pc_q, RV);
    @(negedge clk); rst = 1'b0; en = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule